// File: doc/BRIEF.md
# I2C Bit-Rate Divider Search Unit

This unit is a small sequential calculator. It works out the two-level SCL clock divider for an I2C controller. It takes two inputs, both in kHz: the rate of the source clock and the bus rate the caller wants. The first level of the divider is a sample count from 1 to 8. The second level is a step count, up to a limit that depends on the speed class. The unit looks for the pair whose product is the smallest total division that does not push the bus above the requested rate. It then packs that pair into a timing word and a high-speed word in the layout the SCL generator expects.

A caller pulses `start_i` with both rates applied. Some time later the unit pulses `done_o` for one cycle. In that same cycle `err_o` says whether the rate could be met, and the two words hold the result until the next one. Every division is a ceiling or floor division done bit-serially, one quotient bit per cycle, by a shared restoring divider. A full search therefore takes a few hundred cycles. A rejected target returns at once.

Top module: `i2c_scl_div_search`

## Requirements
- R1: A target rate of 0 kHz, or above 3400 kHz, is rejected without a search. `done_o` and `err_o` are both 1 in the cycle after the start is taken, and both words are 0.
- R2: A target above 400 kHz selects high-speed mode, with a step limit of 8. A target of 400 kHz or less selects standard/fast mode, with a step limit of 64.
- R3: The minimum divisor is ceil(floor(source/2) / target). If it comes out as 0 (source below 2 kHz), the result is an error with both words 0.
- R4: The search tries each sample count s from 1 to 8, with step = ceil(min_div / s), and skips any step above the limit. A candidate replaces the best only if its product s×step is strictly smaller, so the earlier s wins a tie. The search stops as soon as the best product equals the minimum divisor. If no candidate fits, the result is s=8 and step=limit.
- R5: If floor(source / (2×s×step)) is greater than the target, the result is an error with both words 0.
- R6: In standard/fast mode, the timing word carries s−1 in bits 10:8 and step−1 in bits 5:0, and the high-speed word is 0.
- R7: In high-speed mode, the timing word is 0x1303. The high-speed word is 0x0003 with s−1 in bits 14:12 and step−1 in bits 10:8.
- R8: `done_o` is high for exactly one cycle per accepted start. The words and `err_o` keep their values until the next `done_o`.
- R9: A start pulse that arrives while a search is running is ignored and has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request; taken only when the unit is idle |
| src_khz_i | input | SRC_W | Source clock rate in kHz |
| tgt_khz_i | input | TGT_W | Requested bus rate in kHz |
| timing_word_o | output | 16 | Encoded timing word |
| hs_word_o | output | 16 | Encoded high-speed word |
| done_o | output | 1 | One-cycle result strobe |
| err_o | output | 1 | Rate rejected or unsupported; valid with done_o |

## Verification
Random source clocks are paired with targets drawn from four bands:
- zero,
- the standard/fast range,
- the high-speed range,
- above the high-speed ceiling.

Together these bands separate the two step limits, the two encodings and the early rejection path.

Directed cases cover:
- the limit boundaries at 400/401 and 3400/3401 kHz;
- a search that stops early on an exact product;
- a search where no candidate fits and the final check rejects the rate;
- a source too slow to give a divisor.

A start pulse injected mid-search shows whether the running computation is disturbed. A reference model computes every expected word, so a wrong tie choice or a wrong field position shows up as a word mismatch.

// File: rtl/i2cdiv_pkg.sv
package i2cdiv_pkg;

   typedef enum logic [1:0] {
      CALC_IDLE  = 2'd0,
      CALC_MIN   = 2'd1,
      CALC_STEP  = 2'd2,
      CALC_CHECK = 2'd3
   } calc_state_e;

   localparam logic [15:0] HS_TIMING_WORD = 16'h1303;
   localparam logic [15:0] HS_WORD_BASE   = 16'h0003;

endpackage

// File: rtl/i2cdiv_rdiv.sv
// Bit-serial restoring divider: one quotient bit per cycle.
module i2cdiv_rdiv #(
   parameter int NUM_W = 20,
   parameter int DEN_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_i,
   input  logic [NUM_W-1:0] num_i,
   input  logic [DEN_W-1:0] den_i,
   output logic             done_o,
   output logic [NUM_W-1:0] quo_o
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   if (NUM_W < 2) begin : g_bad_num
      $error("i2cdiv_rdiv: NUM_W must be at least 2");
   end
   if (DEN_W < 1) begin : g_bad_den
      $error("i2cdiv_rdiv: DEN_W must be at least 1");
   end

   logic [NUM_W-1:0] q_r, n_r;
   logic [DEN_W-1:0] d_r, r_r;
   logic [CNT_W-1:0] cnt_r;
   logic             busy_r;
   logic [DEN_W:0]   shifted;
   logic [DEN_W:0]   diff;
   logic             ge;

   // Shift the next numerator bit into the partial remainder and trial-subtract.
   always_comb begin
      shifted = {r_r, q_r[NUM_W-1]};
      ge      = shifted >= {1'b0, d_r};
      diff    = shifted - {1'b0, d_r};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r    <= '0;
         n_r    <= '0;
         d_r    <= '0;
         r_r    <= '0;
         cnt_r  <= '0;
         busy_r <= 1'b0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (go_i) begin
            q_r    <= num_i;
            n_r    <= num_i;
            d_r    <= den_i;
            r_r    <= '0;
            cnt_r  <= CNT_W'(NUM_W);
            busy_r <= 1'b1;
         end else if (busy_r) begin
            q_r   <= {q_r[NUM_W-2:0], ge};
            r_r   <= ge ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
            cnt_r <= cnt_r - 1'b1;
            if (cnt_r == CNT_W'(1)) begin
               busy_r <= 1'b0;
               done_o <= 1'b1;
            end
         end
      end
   end

   assign quo_o = q_r;

   // R3: a division is never launched with a zero divisor
   p_div_den_nz_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go_i |-> (den_i != '0));

   // R3: the finished quotient and remainder reconstruct the numerator exactly
   p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ((({{DEN_W{1'b0}}, q_r} * {{NUM_W{1'b0}}, d_r})
                   + {{NUM_W{1'b0}}, r_r}) == {{DEN_W{1'b0}}, n_r})
                 && (r_r < d_r));

endmodule

// File: rtl/i2cdiv_rate_class.sv
// Classifies the requested rate: rejected, speed class, step limit.
module i2cdiv_rate_class #(
   parameter int TGT_W        = 12,
   parameter int LIM_W        = 7,
   parameter int FS_MAX_KHZ   = 400,
   parameter int HS_MAX_KHZ   = 3400,
   parameter int STEP_LIM_STD = 64,
   parameter int STEP_LIM_HS  = 8
) (
   input  logic [TGT_W-1:0] tgt_i,
   output logic             bad_o,
   output logic             hs_o,
   output logic [LIM_W-1:0] lim_o
);
   logic over;

   if (FS_MAX_KHZ >= HS_MAX_KHZ) begin : g_bad_order
      $error("i2cdiv_rate_class: FS_MAX_KHZ must be below HS_MAX_KHZ");
   end

   // Only compare against the ceiling when the port is wide enough to exceed it.
   if (HS_MAX_KHZ < (2 ** TGT_W) - 1) begin : g_over_cmp
      assign over = tgt_i > TGT_W'(HS_MAX_KHZ);
   end else begin : g_over_none
      assign over = 1'b0;
   end

   if (FS_MAX_KHZ < (2 ** TGT_W) - 1) begin : g_hs_cmp
      assign hs_o = tgt_i > TGT_W'(FS_MAX_KHZ);
   end else begin : g_hs_none
      assign hs_o = 1'b0;
   end

   assign bad_o = (tgt_i == '0) || over;
   assign lim_o = hs_o ? LIM_W'(STEP_LIM_HS) : LIM_W'(STEP_LIM_STD);

endmodule

// File: rtl/i2cdiv_encode.sv
// Packs the chosen sample/step pair into the two register words.
module i2cdiv_encode #(
   parameter int SMP_W = 4,
   parameter int LIM_W = 7
) (
   input  logic             hs_i,
   input  logic [SMP_W-1:0] smp_i,
   input  logic [LIM_W-1:0] stp_i,
   output logic [15:0]      timing_o,
   output logic [15:0]      hsw_o
);
   import i2cdiv_pkg::*;

   if (SMP_W > 16 || LIM_W > 16) begin : g_bad_w
      $error("i2cdiv_encode: field widths exceed a 16-bit word");
   end

   logic [15:0] smp_m1, stp_m1;

   always_comb begin
      smp_m1 = 16'(smp_i) - 16'd1;
      stp_m1 = 16'(stp_i) - 16'd1;
      if (hs_i) begin
         timing_o = HS_TIMING_WORD;
         hsw_o    = HS_WORD_BASE
                  | ((smp_m1 & 16'h0007) << 12)
                  | ((stp_m1 & 16'h0007) << 8);
      end else begin
         timing_o = ((smp_m1 & 16'h0007) << 8) | (stp_m1 & 16'h003F);
         hsw_o    = 16'h0000;
      end
   end

endmodule

// File: rtl/i2c_scl_div_search.sv
module i2c_scl_div_search #(
   parameter int SRC_W        = 20,
   parameter int TGT_W        = 12,
   parameter int SAMPLE_MAX   = 8,
   parameter int STEP_LIM_STD = 64,
   parameter int STEP_LIM_HS  = 8,
   parameter int FS_MAX_KHZ   = 400,
   parameter int HS_MAX_KHZ   = 3400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [SRC_W-1:0] src_khz_i,
   input  logic [TGT_W-1:0] tgt_khz_i,
   output logic [15:0]      timing_word_o,
   output logic [15:0]      hs_word_o,
   output logic             done_o,
   output logic             err_o
);
   import i2cdiv_pkg::*;

   localparam int SMP_W  = $clog2(SAMPLE_MAX + 1);
   localparam int LIM_W  = $clog2(STEP_LIM_STD + 1);
   localparam int NUM_W  = SRC_W;
   localparam int DEN_W  = TGT_W;
   localparam int PROD_W = NUM_W + SMP_W;
   localparam int CHK_W  = TGT_W + 2 + SMP_W + LIM_W;

   if (TGT_W >= SRC_W - 1) begin : g_bad_w
      $error("i2c_scl_div_search: TGT_W must be at least 2 below SRC_W");
   end
   if (SMP_W > TGT_W) begin : g_bad_smp
      $error("i2c_scl_div_search: sample count must fit the divisor width");
   end
   if (STEP_LIM_HS > STEP_LIM_STD) begin : g_bad_lim
      $error("i2c_scl_div_search: high-speed limit exceeds standard limit");
   end

   calc_state_e      state;
   logic [SRC_W-1:0] src_q;
   logic [TGT_W-1:0] tgt_q;
   logic             hs_q;
   logic [LIM_W-1:0] lim_q;
   logic [NUM_W-1:0] min_q;
   logic [SMP_W-1:0] smp_q;
   logic [PROD_W-1:0] best_q;
   logic [SMP_W-1:0] bsmp_q;
   logic [LIM_W-1:0] bstp_q;

   logic             div_go;
   logic [NUM_W-1:0] div_num;
   logic [DEN_W-1:0] div_den;
   logic             div_done;
   logic [NUM_W-1:0] div_quo;

   logic             cls_bad, cls_hs;
   logic [LIM_W-1:0] cls_lim;
   logic [15:0]      enc_timing, enc_hs;

   logic [PROD_W-1:0] cand_prod;
   logic              cand_fits, cand_better, cand_exact;
   logic [CHK_W-1:0]  chk_bound;
   logic              chk_fail;

   i2cdiv_rate_class #(
      .TGT_W(TGT_W), .LIM_W(LIM_W), .FS_MAX_KHZ(FS_MAX_KHZ),
      .HS_MAX_KHZ(HS_MAX_KHZ), .STEP_LIM_STD(STEP_LIM_STD),
      .STEP_LIM_HS(STEP_LIM_HS)
   ) u_class (
      .tgt_i(tgt_khz_i), .bad_o(cls_bad), .hs_o(cls_hs), .lim_o(cls_lim)
   );

   i2cdiv_rdiv #(.NUM_W(NUM_W), .DEN_W(DEN_W)) u_div (
      .clk(clk), .rst_n(rst_n), .go_i(div_go), .num_i(div_num),
      .den_i(div_den), .done_o(div_done), .quo_o(div_quo)
   );

   i2cdiv_encode #(.SMP_W(SMP_W), .LIM_W(LIM_W)) u_enc (
      .hs_i(hs_q), .smp_i(bsmp_q), .stp_i(bstp_q),
      .timing_o(enc_timing), .hsw_o(enc_hs)
   );

   // Candidate evaluation for the step count just returned by the divider.
   always_comb begin
      cand_prod   = PROD_W'(div_quo) * PROD_W'(smp_q);
      cand_fits   = div_quo <= NUM_W'(lim_q);
      cand_better = cand_fits && (cand_prod < best_q);
      cand_exact  = cand_prod == PROD_W'(min_q);
   end

   // Achieved rate exceeds target  <=>  source >= (target+1) * 2 * s * step.
   always_comb begin
      chk_bound = (CHK_W'(tgt_q) + CHK_W'(1)) * CHK_W'(2)
                * CHK_W'(bsmp_q) * CHK_W'(bstp_q);
      chk_fail  = CHK_W'(src_q) >= chk_bound;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= CALC_IDLE;
         src_q         <= '0;
         tgt_q         <= '0;
         hs_q          <= 1'b0;
         lim_q         <= '0;
         min_q         <= '0;
         smp_q         <= '0;
         best_q        <= '0;
         bsmp_q        <= '0;
         bstp_q        <= '0;
         div_go        <= 1'b0;
         div_num       <= '0;
         div_den       <= '0;
         timing_word_o <= '0;
         hs_word_o     <= '0;
         done_o        <= 1'b0;
         err_o         <= 1'b0;
      end else begin
         done_o <= 1'b0;
         div_go <= 1'b0;
         unique case (state)
            CALC_IDLE: begin
               if (start_i) begin
                  src_q <= src_khz_i;
                  tgt_q <= tgt_khz_i;
                  hs_q  <= cls_hs;
                  lim_q <= cls_lim;
                  if (cls_bad) begin
                     done_o        <= 1'b1;
                     err_o         <= 1'b1;
                     timing_word_o <= '0;
                     hs_word_o     <= '0;
                  end else begin
                     div_go  <= 1'b1;
                     div_num <= NUM_W'(src_khz_i >> 1) + NUM_W'(tgt_khz_i)
                              - NUM_W'(1);
                     div_den <= tgt_khz_i;
                     state   <= CALC_MIN;
                  end
               end
            end
            CALC_MIN: begin
               if (div_done) begin
                  min_q <= div_quo;
                  if (div_quo == '0) begin
                     done_o        <= 1'b1;
                     err_o         <= 1'b1;
                     timing_word_o <= '0;
                     hs_word_o     <= '0;
                     state         <= CALC_IDLE;
                  end else begin
                     smp_q   <= SMP_W'(1);
                     best_q  <= PROD_W'(SAMPLE_MAX) * PROD_W'(lim_q);
                     bsmp_q  <= SMP_W'(SAMPLE_MAX);
                     bstp_q  <= lim_q;
                     div_go  <= 1'b1;
                     div_num <= div_quo;
                     div_den <= DEN_W'(1);
                     state   <= CALC_STEP;
                  end
               end
            end
            CALC_STEP: begin
               if (div_done) begin
                  if (cand_better) begin
                     best_q <= cand_prod;
                     bsmp_q <= smp_q;
                     bstp_q <= div_quo[LIM_W-1:0];
                  end
                  if ((cand_better && cand_exact) ||
                      (smp_q == SMP_W'(SAMPLE_MAX))) begin
                     state <= CALC_CHECK;
                  end else begin
                     smp_q   <= smp_q + SMP_W'(1);
                     div_go  <= 1'b1;
                     div_num <= min_q + NUM_W'(smp_q);
                     div_den <= DEN_W'(smp_q) + DEN_W'(1);
                  end
               end
            end
            CALC_CHECK: begin
               done_o        <= 1'b1;
               err_o         <= chk_fail;
               timing_word_o <= chk_fail ? 16'h0000 : enc_timing;
               hs_word_o     <= chk_fail ? 16'h0000 : enc_hs;
               state         <= CALC_IDLE;
            end
            default: state <= CALC_IDLE;
         endcase
      end
   end

   // R1: a zero target is refused in the very next cycle
   p_zero_tgt_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CALC_IDLE && start_i && tgt_khz_i == '0) |=> (done_o && err_o));

   // R4: the chosen pair respects the step limit and a valid sample count
   p_pick_in_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == CALC_CHECK) |-> (bstp_q <= lim_q && bstp_q != '0
                                  && bsmp_q != '0
                                  && bsmp_q <= SMP_W'(SAMPLE_MAX)));

   // R5: an error result carries zero words
   p_err_words_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && err_o) |-> (timing_word_o == 16'h0 && hs_word_o == 16'h0));

   // R6: standard/fast results leave the high-speed word clear
   p_std_hs_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && !hs_q) |-> (hs_word_o == 16'h0));

   // R7: high-speed results carry the fixed timing word and base bits
   p_hs_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !err_o && hs_q) |-> (timing_word_o == HS_TIMING_WORD
                                      && hs_word_o[1:0] == 2'b11));

   // R8: results only move together with the done strobe
   p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> ($stable(timing_word_o) && $stable(hs_word_o) && $stable(err_o)));

   // R9: a start during a search does not disturb the captured rates
   p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (state != CALC_IDLE && start_i) |=> ($stable(src_q) && $stable(tgt_q)));

endmodule

// File: tb/tb_i2c_scl_div_search.sv
`timescale 1ns/1ps
module tb_i2c_scl_div_search;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [19:0] src = '0;
   logic [11:0] tgt = '0;
   logic [15:0] timing_w, hs_w;
   logic        done, err;

   int total = 0;
   int bad   = 0;

   i2c_scl_div_search dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .src_khz_i(src),
      .tgt_khz_i(tgt), .timing_word_o(timing_w), .hs_word_o(hs_w),
      .done_o(done), .err_o(err)
   );

   always #4 clk = ~clk;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // Reference model of the divider search, straight from the requirements.
   function automatic void model(input int s_khz, input int t_khz,
                                 output int tw, output int hw, output bit e);
      int lim, md, best, bs, bt, st, sclk;
      tw = 0; hw = 0; e = 0;
      if (t_khz == 0 || t_khz > 3400) begin e = 1; return; end
      lim = (t_khz > 400) ? 8 : 64;
      md = ((s_khz >> 1) + t_khz - 1) / t_khz;
      if (md == 0) begin e = 1; return; end
      best = 8 * lim; bs = 8; bt = lim;
      for (int s = 1; s <= 8; s++) begin
         st = (md + s - 1) / s;
         if (st > lim) continue;
         if (st * s < best) begin
            best = st * s; bs = s; bt = st;
            if (best == md) break;
         end
      end
      sclk = s_khz / (2 * bs * bt);
      if (sclk > t_khz) begin e = 1; return; end
      if (t_khz > 400) begin
         tw = 'h1303;
         hw = 3 | (((bs - 1) & 7) << 12) | (((bt - 1) & 7) << 8);
      end else begin
         tw = (((bs - 1) & 7) << 8) | ((bt - 1) & 63);
         hw = 0;
      end
   endfunction

   task automatic run_calc(input int s_khz, input int t_khz, input string req,
                           input bit poke);
      int etw, ehw, cyc;
      bit ee;
      model(s_khz, t_khz, etw, ehw, ee);
      @(negedge clk);
      src = 20'(s_khz); tgt = 12'(t_khz); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      if (poke) begin
         // R9: a second request mid-search with different rates
         repeat (5) @(negedge clk);
         src = 20'd77777; tgt = 12'd333; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done && cyc < 3000) begin
         @(negedge clk);
         cyc++;
      end
      check(done === 1'b1, {req, " done"}, int'(done), 1);
      check(err === ee, {req, " err"}, int'(err), int'(ee));
      check(timing_w === 16'(etw), {req, " timing"}, int'(timing_w), etw);
      check(hs_w === 16'(ehw), {req, " hs"}, int'(hs_w), ehw);
      @(negedge clk);
      // R8: strobe lasts one cycle, results stay put
      check(done === 1'b0, "R8 done pulse", int'(done), 0);
      check(timing_w === 16'(etw), "R8 hold", int'(timing_w), etw);
   endtask

   initial begin
      #(8ns * 200000);
      bad++;
      total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed_dummy;
      int s_khz, t_khz, band;
      seed_dummy = $urandom(32'd2024);
      repeat (3) @(negedge clk);
      check(done === 1'b0 && err === 1'b0, "R8 reset flags", int'({done, err}), 0);
      check(timing_w === 16'h0 && hs_w === 16'h0, "R8 reset words",
            int'(timing_w), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_calc(26000, 0, "R1 zero target", 1'b0);
      run_calc(26000, 3401, "R1 above ceiling", 1'b0);
      run_calc(26000, 4095, "R1 max input", 1'b0);
      run_calc(150000, 3400, "R2 ceiling high-speed", 1'b0);
      run_calc(150000, 400, "R2 fast boundary", 1'b0);
      run_calc(150000, 401, "R2 first high-speed", 1'b0);
      run_calc(1, 5, "R3 zero divisor", 1'b0);
      run_calc(26000, 100, "R4 early stop", 1'b0);
      run_calc(24000, 100, "R4 tie earlier wins", 1'b0);
      run_calc(200000, 100, "R5 unsupported", 1'b0);
      run_calc(13000, 100, "R6 standard encode", 1'b0);
      run_calc(66000, 1000, "R7 high-speed encode", 1'b0);
      run_calc(26000, 100, "R9 busy start", 1'b1);
      run_calc(98304, 2000, "R9 busy start hs", 1'b1);

      for (int i = 0; i < 60; i++) begin
         s_khz = 2000 + int'($urandom % 500000);
         band  = int'($urandom % 4);
         case (band)
            0: t_khz = 1 + int'($urandom % 400);
            1: t_khz = 401 + int'($urandom % 3000);
            2: t_khz = 3401 + int'($urandom % 695);
            default: t_khz = (i % 2 == 0) ? 0 : 1 + int'($urandom % 100);
         endcase
         run_calc(s_khz, t_khz, (t_khz > 400) ? "R7 random" : "R6 random", 1'b0);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule